// File: doc/BRIEF.md
# Bound-Checked Descriptor Address Unit

This unit turns a 64-bit data descriptor into the address of one element in memory. The descriptor holds a type byte, a 24-bit bound (for a vector) or byte count (for a string), and a 32-bit origin. A signed index can come with it from a separate index register, together with a flag that says whether the operand should be indexed at all. The unit returns a bit address, the element size in bits, and an error flag.

When indexing is requested, the index is checked against the bound in the same cycle as the address is computed. A negative index, or one at or past the bound, gives an error result with a zeroed address and size. An error result stands in place of a memory access. When no indexing is requested, the origin itself is the address and there is no check. Vector elements are 1 to 64 bits wide, and the byte offset is scaled by that width. String elements are single bytes.

Requests and results each use a valid/ready handshake. There is one register stage, so a request accepted on one clock edge gives its result on the following edge.

Top module: `vdesc_unit`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid` is 0 until a request is accepted.
- R2: A request with `in_valid` and `in_ready` high at a rising edge gives its result with `out_valid` high after that edge. `in_ready` equals `!out_valid || out_ready`. A result not taken (`out_ready` low) stays unchanged on the outputs.
- R3: Descriptor bits [63:56] are the type byte, [55:32] the bound or length, and [31:0] the origin. Type bit 63 = 1 selects a string and 0 selects a vector. Type bits 62:59 are ignored.
- R4: For a vector, type bits [58:56] hold a size code c from 0 to 6, and `out_size` = 2^c bits (1, 2, 4, 8, 16, 32, 64).
- R5: For a vector with indexing on and the index in range, `out_addr` = origin×8 + index×2^c.
- R6: For a string with indexing on and the index in range, `out_addr` = (origin + index)×8 and `out_size` = 8.
- R7: With `in_mod_en` low, `out_addr` = origin×8. Neither `in_mod` nor the bound is looked at, so a zero bound or a negative index gives no error.
- R8: With `in_mod_en` high, an index with bit 31 set (negative in two's complement) gives `out_err` = 1.
- R9: With `in_mod_en` high, an index equal to or greater than the bound gives `out_err` = 1, while bound−1 is accepted. A zero bound therefore rejects every index.
- R10: A result with `out_err` = 1 has `out_addr` = 0 and `out_size` = 0.
- R11: A vector with size code 7 is invalid and gives `out_err` = 1 whether or not indexing is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_desc | input | 64 | Descriptor: type, bound/length, origin |
| in_mod | input | 32 | Signed index |
| in_mod_en | input | 1 | Apply index and bound check |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 36 | Element bit address |
| out_size | output | 7 | Element size in bits |
| out_err | output | 1 | Bound or type violation, no access |

## Verification
Every result is due exactly one rising edge after its request is accepted. After that it holds for as long as `out_ready` stays low. The bench drives inputs on the falling edge. On the next falling edge it compares the outputs with a behavioural model that has already taken in that edge's accept or drain. The `in_ready` level is compared on the same falling edge, before the new inputs are applied. Back-pressure is applied at random on top of directed cases at the bound edges (bound−1, bound, zero bound, negative index) and for every size code.

// File: rtl/vdesc_unit.sv
module vdesc_unit #(
  parameter int TYPE_W = 8,
  parameter int BOUND_W = 24,
  parameter int ORIGIN_W = 32,
  parameter int MOD_W = 32,
  parameter int CODE_W = 3,
  localparam int DESC_W = TYPE_W + BOUND_W + ORIGIN_W,
  localparam int AW = ORIGIN_W + 4,
  localparam int SZ_W = (1 << CODE_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DESC_W-1:0] in_desc,
  input  logic [MOD_W-1:0]  in_mod,
  input  logic              in_mod_en,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [AW-1:0]     out_addr,
  output logic [SZ_W-1:0]   out_size,
  output logic              out_err
);

  logic [TYPE_W-1:0]   typ;
  logic [BOUND_W-1:0]  bound;
  logic [ORIGIN_W-1:0] origin;
  logic [CODE_W-1:0]   code;
  logic                is_str;
  logic                bad_code, mod_neg, mod_big, err;
  logic [BOUND_W-1:0]  idx;
  logic [AW-1:0]       vec_addr, str_addr, addr;
  logic [SZ_W-1:0]     size;
  logic                accept;

  assign typ    = in_desc[DESC_W-1 -: TYPE_W];
  assign bound  = in_desc[ORIGIN_W +: BOUND_W];
  assign origin = in_desc[ORIGIN_W-1:0];
  assign is_str = typ[TYPE_W-1];
  assign code   = typ[CODE_W-1:0];

  assign bad_code = !is_str && (&code);
  assign mod_neg  = in_mod[MOD_W-1];
  assign mod_big  = in_mod >= {{(MOD_W-BOUND_W){1'b0}}, bound};
  assign err      = bad_code || (in_mod_en && (mod_neg || mod_big));

  assign idx      = in_mod_en ? in_mod[BOUND_W-1:0] : '0;
  assign vec_addr = (AW'(origin) << 3) + (AW'(idx) << code);
  assign str_addr = (AW'(origin) + AW'(idx)) << 3;
  assign addr     = err ? '0 : (is_str ? str_addr : vec_addr);
  assign size     = err ? '0 : (is_str ? SZ_W'(8) : (SZ_W'(1) << code));

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_size  <= '0;
      out_err   <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_addr  <= addr;
      out_size  <= size;
      out_err   <= err;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

module vdesc_unit_chk #(
  parameter int TYPE_W = 8,
  parameter int BOUND_W = 24,
  parameter int ORIGIN_W = 32,
  parameter int MOD_W = 32,
  parameter int CODE_W = 3,
  localparam int DESC_W = TYPE_W + BOUND_W + ORIGIN_W,
  localparam int AW = ORIGIN_W + 4,
  localparam int SZ_W = (1 << CODE_W) - 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DESC_W-1:0] in_desc,
  input logic [MOD_W-1:0]  in_mod,
  input logic              in_mod_en,
  input logic              out_valid,
  input logic              out_ready,
  input logic [AW-1:0]     out_addr,
  input logic [SZ_W-1:0]   out_size,
  input logic              out_err
);

  logic fire;
  assign fire = in_valid && in_ready;

  // R2
  accept_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_size) && $stable(out_err));

  // R2
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R8
  neg_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_mod_en && in_mod[MOD_W-1] |=> out_err);

  // R10
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> out_addr == '0 && out_size == '0);

  // R7
  plain_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !in_mod_en && (in_desc[DESC_W-1] || !(&in_desc[ORIGIN_W+BOUND_W +: CODE_W]))
    |=> !out_err && out_addr == (AW'($past(in_desc[ORIGIN_W-1:0])) << 3));

endmodule

bind vdesc_unit vdesc_unit_chk #(
  .TYPE_W(TYPE_W), .BOUND_W(BOUND_W), .ORIGIN_W(ORIGIN_W), .MOD_W(MOD_W), .CODE_W(CODE_W)
) u_chk (.*);

// File: tb/vdesc_unit_test.sv
`timescale 1ns/1ps
module vdesc_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_desc = '0;
  logic [31:0] in_mod = '0;
  logic        in_mod_en = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [35:0] out_addr;
  logic [6:0]  out_size;
  logic        out_err;

  int checks = 0;
  int fails = 0;

  bit     exp_valid = 1'b0;
  longint exp_addr = 0;
  int     exp_size = 0;
  bit     exp_err = 1'b0;
  string  exp_tag = "R1";

  always #4 clk = ~clk;

  vdesc_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_desc(in_desc), .in_mod(in_mod), .in_mod_en(in_mod_en),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_size(out_size), .out_err(out_err)
  );

  function automatic logic [63:0] mk(bit str, logic [2:0] code, logic [23:0] bnd, logic [31:0] org);
    return {str, 4'b0, code, bnd, org};
  endfunction

  task automatic ref_calc(input logic [63:0] d, input logic [31:0] m, input bit e,
                          output longint a, output int sz, output bit er, output string tag);
    bit     str  = d[63];
    int     code = int'(d[58:56]);
    longint bnd  = longint'({40'b0, d[55:32]});
    longint org  = longint'({32'b0, d[31:0]});
    longint mi   = longint'($signed(m));
    bit     badc = !str && code == 7;
    er = badc || (e && (mi < 0 || mi >= bnd));
    if (er) begin
      a = 0; sz = 0;
      tag = badc ? "R11" : (mi < 0 ? "R8" : "R9");
    end else begin
      longint k = e ? mi : 0;
      if (str) begin sz = 8; a = (org + k) * 8; end
      else begin sz = 1 << code; a = org * 8 + k * sz; end
      tag = !e ? "R7" : (str ? "R6" : "R5");
    end
  endtask

  task automatic fail_msg(string tag, string what, longint act, longint exp);
    fails++;
    $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
  endtask

  task automatic compare();
    checks++;
    if (in_ready !== (!exp_valid || out_ready)) fail_msg("R2", "in_ready", longint'(in_ready), longint'(!exp_valid || out_ready));
    checks++;
    if (out_valid !== exp_valid) fail_msg(exp_valid ? "R2" : "R1", "out_valid", longint'(out_valid), longint'(exp_valid));
    else if (exp_valid) begin
      checks++;
      if (out_err !== exp_err) fail_msg(exp_tag, "out_err", longint'(out_err), longint'(exp_err));
      checks++;
      if ({28'b0, out_addr} !== exp_addr) fail_msg(exp_tag, "out_addr", longint'({28'b0, out_addr}), exp_addr);
      checks++;
      if (int'(out_size) != exp_size) fail_msg(exp_err ? "R10" : "R4", "out_size", longint'(out_size), longint'(exp_size));
    end
  endtask

  task automatic step(bit v, logic [63:0] d, logic [31:0] m, bit e, bit r);
    @(negedge clk);
    compare();
    in_valid = v; in_desc = d; in_mod = m; in_mod_en = e; out_ready = r;
    if (v && (!exp_valid || r)) begin
      longint a; int sz; bit er; string tg;
      ref_calc(d, m, e, a, sz, er, tg);
      exp_valid = 1'b1; exp_addr = a; exp_size = sz; exp_err = er; exp_tag = tg;
    end else if (r) begin
      exp_valid = 1'b0;
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    // R1: reset holds output idle
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) fail_msg("R1", "out_valid in reset", longint'(out_valid), 0);
    end
    rst_n = 1'b1;
    step(0, '0, '0, 0, 1);
    // R3 R4: every vector size code, unmodified
    for (int c = 0; c < 8; c++) step(1, mk(0, 3'(c), 24'd10, 32'h0000_1000 + 32'(c)), 32'd3, 0, 1);
    // R5: vector indexed, incl. bound-1 with largest element
    step(1, mk(0, 3'd6, 24'd100, 32'h1234_5678), 32'd99, 1, 1);
    step(1, mk(0, 3'd0, 24'd5, 32'hFFFF_FFFF), 32'd4, 1, 1);
    step(1, mk(0, 3'd3, 24'hFFFFFF, 32'd0), 32'h00FF_FFFE, 1, 1);
    // R6: string indexed, ignored type bits set
    step(1, 64'hF800_0040_0000_0100, 32'd63, 1, 1);
    step(1, mk(1, 3'd2, 24'd8, 32'hFFFF_FFF0), 32'd7, 1, 1);
    // R7: no indexing, zero bound and negative index ignored
    step(1, mk(0, 3'd2, 24'd0, 32'h0000_0020), 32'hFFFF_FFFF, 0, 1);
    step(1, mk(1, 3'd0, 24'd0, 32'h8000_0000), 32'h8000_0000, 0, 1);
    // R8: negative index
    step(1, mk(0, 3'd1, 24'd50, 32'h100), 32'hFFFF_FFFF, 1, 1);
    step(1, mk(1, 3'd0, 24'hFFFFFF, 32'h100), 32'h8000_0000, 1, 1);
    // R9: at bound, above bound, zero bound, wide index
    step(1, mk(0, 3'd4, 24'd16, 32'h200), 32'd16, 1, 1);
    step(1, mk(1, 3'd0, 24'd16, 32'h200), 32'd15, 1, 1);
    step(1, mk(1, 3'd0, 24'd16, 32'h200), 32'd16, 1, 1);
    step(1, mk(0, 3'd0, 24'd0, 32'h200), 32'd0, 1, 1);
    step(1, mk(0, 3'd0, 24'hFFFFFF, 32'h200), 32'h0100_0000, 1, 1);
    // R11: code 7 with indexing on
    step(1, mk(0, 3'd7, 24'd16, 32'h200), 32'd1, 1, 1);
    // R2: stall holds result, new request waits
    step(1, mk(0, 3'd5, 24'd9, 32'h300), 32'd8, 1, 0);
    step(1, mk(0, 3'd2, 24'd9, 32'h400), 32'd1, 1, 0);
    step(1, mk(0, 3'd2, 24'd9, 32'h400), 32'd1, 1, 0);
    step(1, mk(0, 3'd2, 24'd9, 32'h400), 32'd1, 1, 1);
    step(0, '0, '0, 0, 0);
    step(0, '0, '0, 0, 1);
    step(0, '0, '0, 0, 1);
    // random traffic with back-pressure
    for (int i = 0; i < 1500; i++) begin
      logic [23:0] b = 24'($urandom_range(0, 40));
      logic [31:0] m;
      int sel = $urandom_range(0, 4);
      if (sel == 0) m = $urandom | 32'h8000_0000;
      else if (sel == 1) m = 32'(b);
      else if (sel == 2) m = 32'(b) - 32'd1;
      else m = 32'($urandom_range(0, 45));
      step($urandom_range(0, 3) != 0,
           mk(1'($urandom), 3'($urandom), b, $urandom),
           m, 1'($urandom), $urandom_range(0, 2) != 0);
    end
    step(0, '0, '0, 0, 1);
    step(0, '0, '0, 0, 1);
    summary();
    $finish;
  end

endmodule